// File: doc/BRIEF.md
# Reload-Match PWM Timer

This block is an up-counting timer that turns two programmable values into a pulse-width modulated output. The reload value sets where the counter restarts after it passes its all-ones value, and therefore sets the period. The match value sets the count at which the output drops, and therefore sets the duty. Every restart drives the output high. Reaching the match value drives it low.

Software programs the timer through a single-cycle write port. The counter, reload and match registers can be rewritten at any time, including while the timer runs. A write lands in the working register at once; nothing is staged until the period ends. As a result, a match write made while the output is high can shorten the current pulse. It can also stretch that pulse across a restart. The control register holds a run bit and an output-enable bit. While the timer runs, it accepts only a request to stop.

Top module: `rm_pwm_timer`

## Requirements
- R1: While reset is applied and after it is released, the count output is zero and the PWM output is low. With the run bit clear, the count does not move.
- R2: Register addresses are 0 for control, 1 for counter, 2 for reload and 3 for match. In the control word, bit 0 is run and bit 1 is output enable. While run is set, the count rises by one on each clock.
- R3: On the clock where the count is all ones, the next count equals the reload register. On the same clock the output goes high, provided output enable is set.
- R4: The output goes low on the clock where the count becomes equal to the match register. The high time is match minus reload clocks. The period is 2^CNT_W minus reload clocks.
- R5: Suppose the output is high and a match value above the current count is written. The output falls when the count reaches the new value within the same period.
- R6: Suppose the output is high and a match value below the current count is written. The output stays high through the next restart. It falls when the count reaches the new value, so the pulse lasts one old period plus the new duty.
- R7: A reload write does not change the length of the period in progress. The next restart loads the new value.
- R8: A counter write replaces the count on the next clock and leaves the output level unchanged. Stepping and comparing then continue from the written value.
- R9: While run is set, a control write that keeps bit 0 at 1 is ignored. A control write with bit 0 at 0 stops the timer: the count freezes and the output is low from the following clock. Setting run again resumes counting from the frozen value.
- R10: With output enable clear, the output stays low while the counter runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Register write strobe, one write per clock |
| wr_addr | input | 2 | Register select: 0 control, 1 counter, 2 reload, 3 match |
| wr_data | input | CNT_W | Write data |
| pwm_out | output | 1 | PWM waveform |
| count_out | output | CNT_W | Current counter value |

## Verification
The hardest situation to reach is a match write that arrives while the output is high and the count has already passed the new value. Only then does the pulse stretch across a restart. The bench reaches it with an 8-bit counter: it starts a period, counts clocks from the rising edge until the count sits past the new target, and issues the match write on exactly that clock. It then checks the total high time against one old period plus the new duty. The same clock-counting approach places the mid-period reload, counter and control writes, and a sweep over match values for several reload values covers the ordinary period and duty arithmetic.

// File: rtl/rmp_pkg.sv
package rmp_pkg;

  typedef enum logic [1:0] {
    ADDR_CTRL   = 2'd0,
    ADDR_COUNT  = 2'd1,
    ADDR_RELOAD = 2'd2,
    ADDR_MATCH  = 2'd3
  } rmp_addr_e;

  // bit 1: output enable, bit 0: run
  typedef struct packed {
    logic pwm_en;
    logic run;
  } rmp_ctrl_t;

endpackage

// File: rtl/rmp_rst_sync.sv
module rmp_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign srst_n = sync_q[1];

endmodule

// File: rtl/rmp_regs.sv
module rmp_regs
  import rmp_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  output rmp_ctrl_t        ctrl_q,
  output logic [CNT_W-1:0] reload_q,
  output logic [CNT_W-1:0] match_q,
  output logic             cnt_load
);

  rmp_ctrl_t ctrl_d;
  logic      ctrl_sel;
  logic      reload_en;
  logic      match_en;

  always_comb begin
    ctrl_sel  = wr_en && (wr_addr == ADDR_CTRL);
    reload_en = wr_en && (wr_addr == ADDR_RELOAD);
    match_en  = wr_en && (wr_addr == ADDR_MATCH);
    cnt_load  = wr_en && (wr_addr == ADDR_COUNT);

    ctrl_d = ctrl_q;
    if (ctrl_sel) begin
      if (!ctrl_q.run)      ctrl_d = rmp_ctrl_t'(wr_data[1:0]);
      else if (!wr_data[0]) ctrl_d.run = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= '0;
    else        ctrl_q <= ctrl_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         reload_q <= '0;
    else if (reload_en) reload_q <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        match_q <= '0;
    else if (match_en) match_q <= wr_data;
  end

endmodule

// File: rtl/rmp_counter.sv
module rmp_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] reload_val,
  output logic [CNT_W-1:0] count_q,
  output logic [CNT_W-1:0] count_d,
  output logic             step,
  output logic             wrap
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic cnt_en;

  always_comb begin
    step   = run && !load;
    wrap   = step && (count_q == CNT_MAX);
    cnt_en = step || load;
    if (load)      count_d = load_val;
    else if (wrap) count_d = reload_val;
    else           count_d = count_q + CNT_ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      count_q <= '0;
    else if (cnt_en) count_q <= count_d;
  end

endmodule

// File: rtl/rmp_pwm_out.sv
module rmp_pwm_out #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             pwm_en,
  input  logic             step,
  input  logic             wrap,
  input  logic [CNT_W-1:0] count_d,
  input  logic [CNT_W-1:0] match_val,
  output logic             pwm_q
);

  logic pwm_d;

  always_comb begin
    if (!run || !pwm_en)                     pwm_d = 1'b0;
    else if (wrap)                           pwm_d = 1'b1;
    else if (step && (count_d == match_val)) pwm_d = 1'b0;
    else                                     pwm_d = pwm_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pwm_q <= 1'b0;
    else        pwm_q <= pwm_d;
  end

endmodule

// File: rtl/rm_pwm_timer.sv
module rm_pwm_timer
  import rmp_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  output logic             pwm_out,
  output logic [CNT_W-1:0] count_out
);

  logic             rst_sync_n;
  rmp_ctrl_t        ctrl_q;
  logic             run_q;
  logic             pwm_en_q;
  logic [CNT_W-1:0] reload_q;
  logic [CNT_W-1:0] match_q;
  logic [CNT_W-1:0] count_d;
  logic             cnt_load;
  logic             step;
  logic             wrap;

  assign run_q    = ctrl_q.run;
  assign pwm_en_q = ctrl_q.pwm_en;

  rmp_rst_sync u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (rst_sync_n)
  );

  rmp_regs #(.CNT_W(CNT_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .ctrl_q   (ctrl_q),
    .reload_q (reload_q),
    .match_q  (match_q),
    .cnt_load (cnt_load)
  );

  rmp_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .run        (run_q),
    .load       (cnt_load),
    .load_val   (wr_data),
    .reload_val (reload_q),
    .count_q    (count_out),
    .count_d    (count_d),
    .step       (step),
    .wrap       (wrap)
  );

  rmp_pwm_out #(.CNT_W(CNT_W)) u_out (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .run       (run_q),
    .pwm_en    (pwm_en_q),
    .step      (step),
    .wrap      (wrap),
    .count_d   (count_d),
    .match_val (match_q),
    .pwm_q     (pwm_out)
  );

endmodule

// File: rtl/rm_pwm_timer_chk.sv
module rm_pwm_timer_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [1:0]       wr_addr,
  input logic [CNT_W-1:0] wr_data,
  input logic             run_q,
  input logic             pwm_en_q,
  input logic [CNT_W-1:0] reload_q,
  input logic [CNT_W-1:0] match_q,
  input logic [CNT_W-1:0] count_out,
  input logic             pwm_out
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic cnt_wr;
  logic ctl_wr;
  assign cnt_wr = wr_en && (wr_addr == 2'd1);
  assign ctl_wr = wr_en && (wr_addr == 2'd0);

  p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    run_q && !cnt_wr && (count_out != CNT_MAX) |=> count_out == $past(count_out) + CNT_ONE);

  p_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    run_q && !cnt_wr && (count_out == CNT_MAX) |=> (count_out == $past(reload_q)) && (pwm_out == $past(pwm_en_q)));

  p_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
    run_q && !cnt_wr && (count_out != CNT_MAX) && (count_out + CNT_ONE == match_q) |=> !pwm_out);

  p_cnt_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr && run_q && pwm_en_q |=> (count_out == $past(wr_data)) && $stable(pwm_out));

  p_ctrl_lock_r9: assert property (@(posedge clk) disable iff (!rst_n)
    run_q && ctl_wr |=> pwm_en_q == $past(pwm_en_q));

  p_stop_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q |=> !pwm_out);

  p_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !pwm_en_q |=> !pwm_out);

endmodule

bind rm_pwm_timer rm_pwm_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .wr_en     (wr_en),
  .wr_addr   (wr_addr),
  .wr_data   (wr_data),
  .run_q     (run_q),
  .pwm_en_q  (pwm_en_q),
  .reload_q  (reload_q),
  .match_q   (match_q),
  .count_out (count_out),
  .pwm_out   (pwm_out)
);

// File: tb/tb_rm_pwm_timer.sv
`timescale 1ns/1ps
module tb_rm_pwm_timer;

  localparam int W    = 8;
  localparam int MAXV = (1 << W) - 1;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         wr_en;
  logic [1:0]   wr_addr;
  logic [W-1:0] wr_data;
  logic         pwm_out;
  logic [W-1:0] count_out;

  int n_chk = 0;
  int n_err = 0;
  int hi    = 0;

  always #2.5 clk = ~clk;

  rm_pwm_timer #(.CNT_W(W)) dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .pwm_out   (pwm_out),
    .count_out (count_out)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    hi += int'(pwm_out);
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a[1:0]; wr_data = d[W-1:0];
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // drive a write on the current negedge, then advance one sampled clock
  task automatic wr_tick(input int a, input int d);
    wr_en = 1'b1; wr_addr = a[1:0]; wr_data = d[W-1:0];
    tick();
    wr_en = 1'b0;
  endtask

  // after return, the next clock restarts the count at rl with the output high
  task automatic start_cfg(input int rl, input int mt);
    wr(0, 0);
    wr(2, rl);
    wr(3, mt);
    wr(1, MAXV);
    wr(0, 3);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    int c;
    int rise_t;
    int rise_c;
    int rls [3] = '{128, 200, 240};
    bit prev;
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    repeat (3) @(negedge clk);
    check(count_out == 0 && pwm_out == 1'b0, "R1 in reset", int'(count_out), 0);
    rst_n = 1'b1;
    repeat (3) tick();
    check(count_out == 0, "R1 count after reset", int'(count_out), 0);
    check(pwm_out == 1'b0, "R1 output after reset", int'(pwm_out), 0);
    repeat (5) tick();
    check(count_out == 0, "R1 stopped count holds", int'(count_out), 0);

    // R3/R4 sweep over match for several reload values
    foreach (rls[i]) begin
      for (int mt = rls[i] + 1; mt <= MAXV; mt++) begin
        start_cfg(rls[i], mt);
        hi = 0;
        tick();
        check(int'(count_out) == rls[i] && pwm_out, "R3 restart value", int'(count_out), rls[i]);
        repeat (MAXV - rls[i]) tick();
        check(hi == mt - rls[i], "R4 high time", hi, mt - rls[i]);
      end
    end
    for (int k = 0; k < 3; k++) begin
      int mt;
      mt = (k == 0) ? 1 : ((k == 1) ? 128 : MAXV);
      start_cfg(0, mt);
      hi = 0;
      repeat (MAXV + 1) tick();
      check(hi == mt, "R4 high time reload 0", hi, mt);
    end

    // R5: raise the match above the count while high
    start_cfg(0, 100);
    hi = 0;
    repeat (50) tick();
    wr_tick(3, 150);
    repeat (MAXV + 1 - 51) tick();
    check(hi == 150, "R5 late larger match", hi, 150);

    // R6: drop the match below the count while high
    start_cfg(0, 200);
    hi = 0;
    repeat (100) tick();
    wr_tick(3, 50);
    repeat (299) tick();
    check(hi == 306, "R6 stretched pulse", hi, 306);
    check(pwm_out == 1'b0, "R6 low after stretch", int'(pwm_out), 0);

    // R7: reload written mid-period
    start_cfg(0, 230);
    rise_t = 0; rise_c = -1;
    tick();
    prev = pwm_out;
    repeat (19) begin tick(); prev = pwm_out; end
    wr_tick(2, 200);
    prev = pwm_out;
    for (int t = 22; t <= 300; t++) begin
      tick();
      if (rise_t == 0 && pwm_out && !prev) begin
        rise_t = t; rise_c = int'(count_out);
      end
      prev = pwm_out;
    end
    check(rise_t == MAXV + 2, "R7 current period length kept", rise_t, MAXV + 2);
    check(rise_c == 200, "R7 new reload at restart", rise_c, 200);

    // R8: counter write while running
    start_cfg(0, 100);
    repeat (10) tick();
    wr_tick(1, 120);
    check(count_out == 120, "R8 count replaced", int'(count_out), 120);
    check(pwm_out == 1'b1, "R8 level kept", int'(pwm_out), 1);
    repeat (MAXV + 1 - 120) tick();
    check(count_out == 0 && pwm_out, "R8 continues from new count", int'(count_out), 0);

    // R9: control lock, stop, resume
    start_cfg(0, 128);
    tick();
    wr_tick(0, 1);
    repeat (MAXV - 1) tick();
    check(pwm_out == 1'b0 && count_out == MAXV, "R9 low before restart", int'(pwm_out), 0);
    tick();
    check(pwm_out == 1'b1, "R9 ignored write kept enable", int'(pwm_out), 1);
    wr(0, 0);
    c = int'(count_out);
    tick();
    check(int'(count_out) == c, "R9 count frozen", int'(count_out), c);
    check(pwm_out == 1'b0, "R9 output low when stopped", int'(pwm_out), 0);
    tick();
    check(int'(count_out) == c, "R9 count still frozen", int'(count_out), c);
    wr(0, 3);
    check(int'(count_out) == c, "R9 resume from frozen", int'(count_out), c);
    tick();
    check(int'(count_out) == ((c + 1) & MAXV), "R9 resumed stepping", int'(count_out), (c + 1) & MAXV);

    // R2/R10: run without output enable
    wr(0, 0);
    wr(2, 0);
    wr(3, 10);
    wr(0, 1);
    c = int'(count_out);
    hi = 0;
    tick();
    check(int'(count_out) == ((c + 1) & MAXV), "R2 single step", int'(count_out), (c + 1) & MAXV);
    repeat (300) tick();
    check(hi == 0, "R10 output held low", hi, 0);
    check(int'(count_out) == ((c + 301) & MAXV), "R2 steady counting", int'(count_out), (c + 301) & MAXV);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule